// File: doc/BRIEF.md
# Memory Write Burst Master

This block is the bus-master engine for moving data from a peripheral into system memory over a 32-bit multiplexed address/data bus. The peripheral pushes words into a small synchronous receive FIFO. The engine watches how many words the FIFO holds and requests the bus once enough words are waiting. It also requests the bus when a word has waited too long. After the grant it drives one address cycle carrying the current memory pointer. It then streams FIFO words, one per clock, advancing the pointer and counting down the remaining-word budget.

A burst closes after the word that empties the FIFO, after the word that uses up the budget, or after the word that sits at the top of a 64-word-aligned block. A burst therefore never crosses such a block. An error from the bus aborts the transfer at once. The error leaves a sticky flag and freezes the pointer and the count, so they mark the failing word. The pointer, count, threshold and flush limit are loaded through a simple write port.

Top module: `rx_burst_master`

## Requirements
- R1: No burst is requested while the remaining-word count is zero. The count drops by one for each word sent to memory. A burst closes after the word that brings the count to zero.
- R2: Without a flush, a burst is requested only when the FIFO holds at least 2^code words. The threshold code (0..3) selects 1, 2, 4 or 8 words.
- R3: The grant (`busAckN` low) may come in the same cycle as the request. The engine waits in request while the grant is high. The cycle after the grant is sampled low is the only address cycle, and it drives `dataPtr` on `busAd`.
- R4: Data words follow the address cycle at one word per clock, in FIFO order.
- R5: `busReqN` stays low from the request through the last data word and rises after it. `busAdOe` is high only while `busReqN` is low.
- R6: A burst closes after the word that leaves the FIFO empty. Words pushed during a burst extend it beyond the threshold.
- R7: A burst closes after the word whose pointer has bits [7:2] all ones. The next burst starts at the 64-word-aligned address.
- R8: When a word has waited in the FIFO for the programmed flush limit in cycles while the engine is idle, a burst starts even below the threshold.
- R9: `dataPtr` advances by 4 (one word) for each word sent.
- R10: `busErrN` low in an address or data cycle aborts the burst. That word is not consumed. `errFlag` is set, and `dataPtr` and `wordsLeft` hold their values. No new request is made until the count is rewritten, and that rewrite clears the flag.
- R11: After a nonzero count load, `donePulse` is high for exactly one cycle once the count is zero and the FIFO is empty.
- R12: After reset, `busReqN` is high, `busAdOe`, `errFlag` and `donePulse` are low, and the pointer, count and FIFO level are zero. `cfgWe` loads the field chosen by `cfgSel`: 0 = pointer, 1 = count (bits 23:0), 2 = threshold code (bits 1:0), 3 = flush limit (bits 15:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration field select |
| cfgData | input | 32 | Configuration write data |
| pushValid | input | 1 | Peripheral offers a word |
| pushData | input | 32 | Peripheral word |
| pushReady | output | 1 | FIFO has room |
| fifoLevel | output | 5 | Words held in the FIFO |
| busReqN | output | 1 | Active-low write request |
| busAckN | input | 1 | Active-low grant |
| busErrN | input | 1 | Active-low bus error |
| busAd | output | 32 | Address/data out |
| busAdOe | output | 1 | Drive enable for busAd |
| dataPtr | output | 32 | Current memory byte address |
| wordsLeft | output | 24 | Remaining-word count |
| errFlag | output | 1 | Sticky error |
| donePulse | output | 1 | Transfer-complete pulse |

## Verification
The assertions assume that configuration writes happen only while the engine is idle. They also assume that the grant is given only in answer to a pending request and that the error input is pulled only in cycles where the engine owns the bus. The bench grants only after it sees `busReqN` low, with a programmable delay. It raises the error only in a data cycle that it has counted. It rewrites fields only after the bus has gone quiet.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ADDR = 2'd2,
    ST_DATA = 2'd3
  } burstState_t;

  typedef struct packed {
    logic advance;    // word leaves FIFO, pointer and count step
    logic setErr;     // bus error seen while owning the bus
    logic inIdle;     // engine not holding the bus
    logic driveAddr;  // address cycle
    logic driveData;  // data cycle
  } burstStrobe_t;

  localparam logic [1:0] CFG_PTR    = 2'd0;
  localparam logic [1:0] CFG_COUNT  = 2'd1;
  localparam logic [1:0] CFG_THRESH = 2'd2;
  localparam logic [1:0] CFG_FLUSH  = 2'd3;

endpackage

// File: rtl/rbm_fifo.sv
module rbm_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] headData,
  output logic [LVL_W-1:0]  level,
  output logic              full
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic              empty;
  logic              doPush;
  logic              doPop;

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign doPush   = pushEn && !full;
  assign doPop    = popEn && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= rdPtr + PTR_W'(1);
      case ({doPush, doPop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    popEn |-> !empty);  // R6
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));  // R6

endmodule

// File: rtl/rbm_ctrl.sv
module rbm_ctrl
  import rbm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startOk,
  input  logic         lastWord,
  input  logic         busAckN,
  input  logic         busErrN,
  output logic         busReqN,
  output burstStrobe_t strobe
);

  burstState_t state;
  burstState_t stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    strobe.inIdle    = (state == ST_IDLE);
    strobe.driveAddr = (state == ST_ADDR);
    strobe.driveData = (state == ST_DATA);
    case (state)
      ST_IDLE: if (startOk) stateNext = ST_REQ;
      ST_REQ:  if (!busAckN) stateNext = ST_ADDR;
      ST_ADDR: begin
        if (!busErrN) begin
          strobe.setErr = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          stateNext = ST_DATA;
        end
      end
      ST_DATA: begin
        if (!busErrN) begin
          strobe.setErr = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          strobe.advance = 1'b1;
          if (lastWord) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busReqN = (state == ST_IDLE);

  AST_GRANT_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REQ && busAckN) |=> (state == ST_REQ));  // R3
  AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && busErrN) |=> (state == ST_DATA));  // R4
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ADDR || state == ST_DATA) && !busErrN) |=> (state == ST_IDLE));  // R10

endmodule

// File: rtl/rbm_datapath.sv
module rbm_datapath
  import rbm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 24,
  parameter int FLUSH_W   = 16,
  parameter int BND_WORDS = 64,
  parameter int LVL_W     = 5,
  localparam int BND_BITS = $clog2(BND_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [ADDR_W-1:0]  cfgData,
  input  burstStrobe_t       strobe,
  input  logic [LVL_W-1:0]   fifoLevel,
  output logic               startOk,
  output logic               lastWord,
  output logic [ADDR_W-1:0]  dataPtr,
  output logic [CNT_W-1:0]   wordsLeft,
  output logic               errFlag,
  output logic               donePulse
);

  logic [1:0]         thrCode;
  logic [LVL_W-1:0]   thrWords;
  logic [FLUSH_W-1:0] flushLimit;
  logic [FLUSH_W-1:0] flushCnt;
  logic               flushHit;
  logic               bndHit;
  logic               doneArmed;
  logic               fifoEmpty;

  assign fifoEmpty = (fifoLevel == '0);
  assign thrWords  = LVL_W'(1) << thrCode;
  assign flushHit  = (flushCnt >= flushLimit);
  assign bndHit    = &dataPtr[BND_BITS+1:2];

  assign startOk  = strobe.inIdle && !errFlag && (wordsLeft != '0) && !fifoEmpty &&
                    ((fifoLevel >= thrWords) || flushHit);
  assign lastWord = (wordsLeft == CNT_W'(1)) || (fifoLevel == LVL_W'(1)) || bndHit;

  // pointer and count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataPtr   <= '0;
      wordsLeft <= '0;
    end else if (cfgWe && cfgSel == CFG_PTR) begin
      dataPtr <= cfgData;
    end else if (cfgWe && cfgSel == CFG_COUNT) begin
      wordsLeft <= cfgData[CNT_W-1:0];
    end else if (strobe.advance) begin
      dataPtr   <= dataPtr + ADDR_W'(4);
      wordsLeft <= wordsLeft - CNT_W'(1);
    end
  end

  // threshold and flush configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrCode    <= '0;
      flushLimit <= '0;
    end else if (cfgWe) begin
      if (cfgSel == CFG_THRESH) thrCode    <= cfgData[1:0];
      if (cfgSel == CFG_FLUSH)  flushLimit <= cfgData[FLUSH_W-1:0];
    end
  end

  // wait timer for the oldest stored word
  always_ff @(posedge clk) begin
    if (!rstN)                            flushCnt <= '0;
    else if (!strobe.inIdle || fifoEmpty) flushCnt <= '0;
    else if (!flushHit)                   flushCnt <= flushCnt + FLUSH_W'(1);
  end

  // sticky error
  always_ff @(posedge clk) begin
    if (!rstN)                              errFlag <= 1'b0;
    else if (cfgWe && cfgSel == CFG_COUNT) errFlag <= 1'b0;
    else if (strobe.setErr)                 errFlag <= 1'b1;
  end

  // completion pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneArmed <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      if (cfgWe && cfgSel == CFG_COUNT) begin
        doneArmed <= (cfgData[CNT_W-1:0] != '0);
      end else if (doneArmed && strobe.inIdle && wordsLeft == '0 && fifoEmpty) begin
        doneArmed <= 1'b0;
        donePulse <= 1'b1;
      end
    end
  end

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (wordsLeft != '0));  // R1
  AST_BOUNDARY_END: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && bndHit) |=> !strobe.advance);  // R7
  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && $past(errFlag) && !$past(cfgWe)) |-> ($stable(dataPtr) && $stable(wordsLeft)));  // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);  // R11

endmodule

// File: rtl/rx_burst_master.sv
module rx_burst_master
  import rbm_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 24,
  parameter int FIFO_DEPTH = 16,
  parameter int FLUSH_W    = 16,
  parameter int BND_WORDS  = 64,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  output logic              pushReady,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              busReqN,
  input  logic              busAckN,
  input  logic              busErrN,
  output logic [DATA_W-1:0] busAd,
  output logic              busAdOe,
  output logic [DATA_W-1:0] dataPtr,
  output logic [CNT_W-1:0]  wordsLeft,
  output logic              errFlag,
  output logic              donePulse
);

  burstStrobe_t      strobe;
  logic              startOk;
  logic              lastWord;
  logic              fifoFull;
  logic [DATA_W-1:0] headData;

  rbm_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) uFifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (pushValid),
    .pushData (pushData),
    .popEn    (strobe.advance),
    .headData (headData),
    .level    (fifoLevel),
    .full     (fifoFull)
  );

  rbm_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startOk  (startOk),
    .lastWord (lastWord),
    .busAckN  (busAckN),
    .busErrN  (busErrN),
    .busReqN  (busReqN),
    .strobe   (strobe)
  );

  rbm_datapath #(
    .ADDR_W(DATA_W), .CNT_W(CNT_W), .FLUSH_W(FLUSH_W),
    .BND_WORDS(BND_WORDS), .LVL_W(LVL_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .strobe    (strobe),
    .fifoLevel (fifoLevel),
    .startOk   (startOk),
    .lastWord  (lastWord),
    .dataPtr   (dataPtr),
    .wordsLeft (wordsLeft),
    .errFlag   (errFlag),
    .donePulse (donePulse)
  );

  assign pushReady = !fifoFull;
  assign busAdOe   = strobe.driveAddr || strobe.driveData;
  assign busAd     = strobe.driveAddr ? dataPtr :
                     strobe.driveData ? headData : '0;

  AST_OE_UNDER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busAdOe |-> !busReqN);  // R5
  AST_REQ_HAS_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReqN) |-> ($past(fifoLevel) != '0 && $past(wordsLeft) != '0));  // R2

endmodule

// File: tb/rx_burst_master_test.sv
module rx_burst_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic        pushValid = 1'b0;
  logic [31:0] pushData = '0;
  logic        pushReady;
  logic [4:0]  fifoLevel;
  logic        busReqN;
  logic        busAckN = 1'b1;
  logic        busErrN = 1'b1;
  logic [31:0] busAd;
  logic        busAdOe;
  logic [31:0] dataPtr;
  logic [23:0] wordsLeft;
  logic        errFlag;
  logic        donePulse;

  int errors = 0;
  int checks = 0;

  // bus-side log
  logic [31:0] rxData [64];
  logic [31:0] addrs [16];
  int          lens [16];
  int          rxN = 0;
  int          nBursts = 0;
  int          sawReq = 0;
  int          doneCnt = 0;
  int          ackDelay = 0;
  int          reqWait = 0;
  int          errAt = 0;
  int          errArmed = 0;
  logic        prevOe = 1'b0;

  rx_burst_master uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .pushValid(pushValid), .pushData(pushData), .pushReady(pushReady),
    .fifoLevel(fifoLevel), .busReqN(busReqN), .busAckN(busAckN), .busErrN(busErrN),
    .busAd(busAd), .busAdOe(busAdOe), .dataPtr(dataPtr), .wordsLeft(wordsLeft),
    .errFlag(errFlag), .donePulse(donePulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory-side model: grant, error injection and logging, all at negedge
  always @(negedge clk) begin
    busErrN = 1'b1;
    if (!busReqN) begin
      sawReq = sawReq + 1;
      if (reqWait >= ackDelay) busAckN = 1'b0;
      else reqWait = reqWait + 1;
    end else begin
      reqWait = 0;
      busAckN = 1'b1;
    end
    if (donePulse) doneCnt = doneCnt + 1;
    if (busAdOe && !prevOe) begin
      addrs[nBursts % 16] = busAd;
      lens[nBursts % 16] = 0;
      nBursts = nBursts + 1;
    end else if (busAdOe) begin
      if (errArmed != 0 && lens[(nBursts-1) % 16] == errAt) begin
        busErrN = 1'b0;
        errArmed = 0;
      end else begin
        rxData[rxN % 64] = busAd;
        rxN = rxN + 1;
        lens[(nBursts-1) % 16] = lens[(nBursts-1) % 16] + 1;
      end
    end
    prevOe = busAdOe;
  end

  task automatic checkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(logic [1:0] sel, logic [31:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pushWords(int n, logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pushValid = 1'b1;
      pushData  = base + 32'(i);
    end
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic clearLog();
    rxN = 0; nBursts = 0; sawReq = 0; doneCnt = 0;
  endtask

  task automatic testReset();
    checkEq("R12", "reqN", 32'(busReqN), 32'd1);
    checkEq("R12", "oe", 32'(busAdOe), 32'd0);
    checkEq("R12", "errFlag", 32'(errFlag), 32'd0);
    checkEq("R12", "level", 32'(fifoLevel), 32'd0);
    checkEq("R12", "wordsLeft", 32'(wordsLeft), 32'd0);
    checkEq("R12", "dataPtr", dataPtr, 32'd0);
  endtask

  task automatic testThreshold();
    clearLog();
    cfgWrite(2'd0, 32'h1000);
    cfgWrite(2'd1, 32'd6);
    cfgWrite(2'd2, 32'd2);          // four words
    cfgWrite(2'd3, 32'hFFFF);
    pushWords(3, 32'hA0);
    waitCycles(20);
    checkEq("R2", "requests below threshold", 32'(sawReq), 32'd0);
    pushWords(1, 32'hA3);
    waitCycles(20);
    checkEq("R2", "bursts", 32'(nBursts), 32'd1);
    checkEq("R3", "address", addrs[0], 32'h1000);
    checkEq("R6", "length to empty", 32'(lens[0]), 32'd4);
    for (int i = 0; i < 4; i++) checkEq("R4", "data order", rxData[i], 32'hA0 + 32'(i));
    checkEq("R1", "count after", 32'(wordsLeft), 32'd2);
    checkEq("R9", "pointer after", dataPtr, 32'h1010);
    checkEq("R5", "reqN released", 32'(busReqN), 32'd1);
  endtask

  task automatic testCountEnd();
    cfgWrite(2'd3, 32'd8);
    pushWords(3, 32'hB0);
    waitCycles(40);
    checkEq("R8", "flush burst", 32'(nBursts), 32'd2);
    checkEq("R1", "length limited by count", 32'(lens[1]), 32'd2);
    checkEq("R1", "count zero", 32'(wordsLeft), 32'd0);
    checkEq("R1", "word left behind", 32'(fifoLevel), 32'd1);
    checkEq("R9", "pointer", dataPtr, 32'h1018);
    checkEq("R11", "no done while FIFO holds data", 32'(doneCnt), 32'd0);
    cfgWrite(2'd1, 32'd1);
    waitCycles(30);
    checkEq("R1", "burst after reload", 32'(nBursts), 32'd3);
    checkEq("R4", "leftover word", rxData[6], 32'hB2);
    checkEq("R11", "one done pulse", 32'(doneCnt), 32'd1);
  endtask

  task automatic testBoundary();
    clearLog();
    ackDelay = 3;
    cfgWrite(2'd0, 32'h10F8);
    cfgWrite(2'd1, 32'd8);
    cfgWrite(2'd2, 32'd3);          // eight words
    cfgWrite(2'd3, 32'd12);
    pushWords(8, 32'hC0);
    waitCycles(70);
    checkEq("R7", "bursts", 32'(nBursts), 32'd2);
    checkEq("R3", "first address with delayed grant", addrs[0], 32'h10F8);
    checkEq("R7", "cut at boundary", 32'(lens[0]), 32'd2);
    checkEq("R7", "next address aligned", addrs[1], 32'h1100);
    checkEq("R8", "flushed remainder", 32'(lens[1]), 32'd6);
    checkEq("R4", "last word", rxData[7], 32'hC7);
    checkEq("R9", "pointer", dataPtr, 32'h1118);
    ackDelay = 0;
  endtask

  task automatic testStream();
    clearLog();
    cfgWrite(2'd0, 32'h2000);
    cfgWrite(2'd1, 32'd20);
    cfgWrite(2'd2, 32'd0);          // one word
    cfgWrite(2'd3, 32'hFFFF);
    pushWords(10, 32'hD0);
    waitCycles(40);
    checks++;
    if (lens[0] < 2) begin
      errors++;
      $display("FAIL R6 streaming burst length actual=%0d expected=>=2", lens[0]);
    end
    checkEq("R4", "words delivered", 32'(rxN), 32'd10);
    for (int i = 0; i < 10; i++) checkEq("R4", "stream order", rxData[i], 32'hD0 + 32'(i));
    checkEq("R1", "count", 32'(wordsLeft), 32'd10);
    checkEq("R9", "pointer", dataPtr, 32'h2028);
  endtask

  task automatic testError();
    clearLog();
    cfgWrite(2'd0, 32'h3000);
    cfgWrite(2'd1, 32'd8);
    cfgWrite(2'd2, 32'd1);          // two words
    cfgWrite(2'd3, 32'hFFFF);
    errAt = 2; errArmed = 1;
    pushWords(4, 32'hE0);
    waitCycles(30);
    checkEq("R10", "errFlag", 32'(errFlag), 32'd1);
    checkEq("R10", "frozen pointer", dataPtr, 32'h3008);
    checkEq("R10", "frozen count", 32'(wordsLeft), 32'd6);
    checkEq("R10", "word not consumed", 32'(fifoLevel), 32'd2);
    pushWords(2, 32'hF0);
    waitCycles(30);
    checkEq("R10", "no burst while flagged", 32'(nBursts), 32'd1);
    checkEq("R10", "level kept", 32'(fifoLevel), 32'd4);
    cfgWrite(2'd1, 32'd6);
    waitCycles(30);
    checkEq("R10", "flag cleared", 32'(errFlag), 32'd0);
    checkEq("R10", "resume address", addrs[1], 32'h3008);
    checkEq("R10", "resumed word", rxData[2], 32'hE2);
    checkEq("R4", "later word", rxData[5], 32'hF1);
    checkEq("R9", "pointer", dataPtr, 32'h3018);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);
    testReset();
    testThreshold();
    testCountEnd();
    testBoundary();
    testStream();
    testError();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule